// File: doc/BRIEF.md
# PCG32 Random Word Generator

This block produces a stream of 32-bit pseudo-random words from a 64-bit linear congruential state. Each word comes from a permutation of the state as it stood before the advance: an xorshift that folds high bits downward, then a right rotation whose amount is taken from the top bits of that same state. A 64-bit seed and a 64-bit stream selector choose the sequence. Different stream selectors give independent sequences from the same seed.

A pulse on `load_i` captures a seed and a stream selector and starts a fixed seeding routine that takes four clock edges. During the routine the block runs two silent advances around the addition of the seed. When the routine ends, `ready_o` goes high. From then on each accepted `next_i` strobe yields one word one cycle later. The block also gives two derived views of the draws. The first is a non-negative 31-bit view of the current word. The second is a 64-bit word built from each consecutive pair of draws.

Top module: `pcg32_gen`

## Requirements
- R1: The increment is the stream selector shifted left by one bit, with bit 0 forced to 1. Bit 63 of the selector therefore has no effect on the sequence.
- R2: Each accepted draw advances the state to state × 6364136223846793005 + increment, modulo 2^64. While ready and without a strobe, the state holds.
- R3: A word is computed from the state before the advance. The state is XORed with itself shifted right by 18, the result is shifted right by 27, and the low 32 bits are kept.
- R4: That 32-bit value is rotated right by the state's bits 63:59. A rotation amount of zero returns the value unchanged.
- R5: Seeding clears the state, sets the increment, advances once, adds the seed, and advances once more. With seed 42 and stream 54, the first word is 0xA15C02B7.
- R6: `ready_o` is low from a load edge onward and rises on the fourth rising edge counted from the load edge, which is edge 1.
- R7: `next_i` strobes while `ready_o` is low are ignored. They raise no `word_valid_o` and do not advance the state.
- R8: A strobe accepted on a rising edge puts its word on `word_o` with `word_valid_o` high for the cycle after that edge. Strobes on back-to-back edges give back-to-back words.
- R9: `wide_o` holds the first draw of a pair in bits 31:0 and the second draw in bits 63:32. `wide_valid_o` is high together with the `word_valid_o` of the second draw. Pairing restarts at every load.
- R10: `pos31_o` equals `word_o` ANDed with 0x7FFFFFFF.
- R11: A load while ready, or on the same edge as a strobe, takes priority. It restarts seeding with the new seed and stream selector.
- R12: After reset, `ready_o`, `word_valid_o` and `wide_valid_o` are low until a load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start seeding with seed_i and stream_i |
| seed_i | input | 64 | Seed value |
| stream_i | input | 64 | Stream selector |
| next_i | input | 1 | Draw strobe |
| ready_o | output | 1 | Seeding complete, draws accepted |
| word_o | output | 32 | Last drawn word |
| word_valid_o | output | 1 | word_o updated this cycle |
| pos31_o | output | 32 | word_o with bit 31 cleared |
| wide_o | output | 64 | Last completed pair of draws |
| wide_valid_o | output | 1 | wide_o updated this cycle |

## Verification
A wrong state bit, a wrong increment or a misordered seeding step corrupts the very first word after `ready_o`. It then corrupts every later word, so a single mismatch against an independent model shows it within one draw. A state that advances on an ignored strobe shifts the whole sequence by one position. That shift shows on the first word after ready. A wrong rotation shows on about 31 of every 32 draws. A wrong pairing shows on the next `wide_valid_o`.

// File: rtl/pcg32_pkg.sv
package pcg32_pkg;
  localparam int unsigned STATE_W = 64;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ROT_W   = 5;
  localparam int unsigned FOLD_SH = 18;
  localparam int unsigned DROP_SH = 27;
  localparam logic [STATE_W-1:0] LCG_MULT = 64'd6364136223846793005;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADV1 = 3'd1,
    PH_ADD  = 3'd2,
    PH_ADV2 = 3'd3,
    PH_RUN  = 3'd4
  } phase_t;

  function automatic logic [STATE_W-1:0] make_inc(input logic [STATE_W-1:0] stream);
    return {stream[STATE_W-2:0], 1'b1};
  endfunction

  function automatic logic [STATE_W-1:0] lcg_step(input logic [STATE_W-1:0] s,
                                                  input logic [STATE_W-1:0] inc);
    return s * LCG_MULT + inc;
  endfunction

  function automatic logic [WORD_W-1:0] fold_bits(input logic [STATE_W-1:0] s);
    logic [STATE_W-1:0] t;
    t = (s ^ (s >> FOLD_SH)) >> DROP_SH;
    return t[WORD_W-1:0];
  endfunction

  function automatic logic [ROT_W-1:0] rot_amount(input logic [STATE_W-1:0] s);
    return s[STATE_W-1 -: ROT_W];
  endfunction

  // rotation through a doubled copy: no shift ever reaches the word width
  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x,
                                             input logic [ROT_W-1:0] r);
    logic [2*WORD_W-1:0] d;
    d = {x, x} >> r;
    return d[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/pcg32_core.sv
module pcg32_core
  import pcg32_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic [STATE_W-1:0] stream_i,
  input  logic               next_i,
  output logic [STATE_W-1:0] state_o,
  output logic               draw_o,
  output logic               ready_o
);
  phase_t             phase_q;
  logic [STATE_W-1:0] state_q, inc_q, seed_q;

  assign ready_o = (phase_q == PH_RUN);
  assign draw_o  = ready_o && next_i && !load_i;
  assign state_o = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      state_q <= '0;
      inc_q   <= '0;
      seed_q  <= '0;
    end else if (load_i) begin
      seed_q  <= seed_i;
      inc_q   <= make_inc(stream_i);
      state_q <= '0;
      phase_q <= PH_ADV1;
    end else begin
      unique case (phase_q)
        PH_ADV1: begin
          state_q <= lcg_step(state_q, inc_q);
          phase_q <= PH_ADD;
        end
        PH_ADD: begin
          state_q <= state_q + seed_q;
          phase_q <= PH_ADV2;
        end
        PH_ADV2: begin
          state_q <= lcg_step(state_q, inc_q);
          phase_q <= PH_RUN;
        end
        PH_RUN: if (draw_o) state_q <= lcg_step(state_q, inc_q);
        default: phase_q <= phase_q;
      endcase
    end
  end

  // R6
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(phase_q == PH_ADV2));

  // R5
  first_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADV1 && !load_i) |=> (state_q == inc_q));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !next_i && !load_i) |=> $stable(state_q));
endmodule

// File: rtl/pcg32_perm.sv
module pcg32_perm
  import pcg32_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic [WORD_W-1:0]  word_o
);
  logic [WORD_W-1:0] folded;
  logic [ROT_W-1:0]  amt;

  assign folded = fold_bits(state_i);
  assign amt    = rot_amount(state_i);
  assign word_o = rotr(folded, amt);

  // R4
  always_comb begin
    rot_bits_chk: assert ($countones(word_o) == $countones(folded))
      else $error("rotation changed the bit count");
  end
endmodule

// File: rtl/pcg32_pair.sv
module pcg32_pair
  import pcg32_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart_i,
  input  logic                draw_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic [WORD_W-1:0]   word_o,
  output logic                word_valid_o,
  output logic [2*WORD_W-1:0] wide_o,
  output logic                wide_valid_o
);
  logic              half_q;
  logic [WORD_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q       <= 1'b0;
      lo_q         <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
      wide_o       <= '0;
      wide_valid_o <= 1'b0;
    end else if (restart_i) begin
      half_q       <= 1'b0;
      word_valid_o <= 1'b0;
      wide_valid_o <= 1'b0;
    end else if (draw_i) begin
      word_o       <= word_i;
      word_valid_o <= 1'b1;
      if (!half_q) begin
        lo_q         <= word_i;
        half_q       <= 1'b1;
        wide_valid_o <= 1'b0;
      end else begin
        wide_o       <= {word_i, lo_q};
        half_q       <= 1'b0;
        wide_valid_o <= 1'b1;
      end
    end else begin
      word_valid_o <= 1'b0;
      wide_valid_o <= 1'b0;
    end
  end

  // R9
  wide_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wide_valid_o |-> (word_valid_o && wide_o[2*WORD_W-1:WORD_W] == word_o));
endmodule

// File: rtl/pcg32_gen.sv
module pcg32_gen
  import pcg32_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [STATE_W-1:0]  seed_i,
  input  logic [STATE_W-1:0]  stream_i,
  input  logic                next_i,
  output logic                ready_o,
  output logic [WORD_W-1:0]   word_o,
  output logic                word_valid_o,
  output logic [WORD_W-1:0]   pos31_o,
  output logic [2*WORD_W-1:0] wide_o,
  output logic                wide_valid_o
);
  logic [STATE_W-1:0] state_w;
  logic               draw_w;
  logic [WORD_W-1:0]  perm_w;

  pcg32_core u_core (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i),
    .stream_i(stream_i), .next_i(next_i), .state_o(state_w),
    .draw_o(draw_w), .ready_o(ready_o)
  );

  pcg32_perm u_perm (.state_i(state_w), .word_o(perm_w));

  pcg32_pair u_pair (
    .clk(clk), .rst_n(rst_n), .restart_i(load_i), .draw_i(draw_w),
    .word_i(perm_w), .word_o(word_o), .word_valid_o(word_valid_o),
    .wide_o(wide_o), .wide_valid_o(wide_valid_o)
  );

  assign pos31_o = {1'b0, word_o[WORD_W-2:0]};

  // R7
  unready_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && next_i) |=> !word_valid_o);

  // R10
  pos31_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (pos31_o[WORD_W-1] == 1'b0 && pos31_o[WORD_W-2:0] == word_o[WORD_W-2:0]));
endmodule

// File: tb/pcg32_gen_bench.sv
module pcg32_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [63:0] seed_i = '0;
  logic [63:0] stream_i = '0;
  logic        next_i = 1'b0;
  logic        ready_o, word_valid_o, wide_valid_o;
  logic [31:0] word_o, pos31_o;
  logic [63:0] wide_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int rot0_seen = 0;
  bit done = 1'b0;

  longint unsigned m_state, m_inc;
  bit          m_half;
  logic [31:0] m_lo;
  logic [31:0] exp_q[$];
  logic [63:0] wide_q[$];
  logic [31:0] capt_a[8];

  always #4 clk = ~clk;

  pcg32_gen u_pcg32_gen (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i),
    .stream_i(stream_i), .next_i(next_i), .ready_o(ready_o),
    .word_o(word_o), .word_valid_o(word_valid_o), .pos31_o(pos31_o),
    .wide_o(wide_o), .wide_valid_o(wide_valid_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model: rotation done one bit at a time
  function automatic logic [31:0] model_word(input longint unsigned s);
    logic [63:0] t;
    logic [31:0] x, r;
    int amt;
    t = (s >> 18) ^ s;
    t = t >> 27;
    x = t[31:0];
    amt = int'(s >> 59);
    for (int i = 0; i < 32; i++) r[i] = x[(i + amt) % 32];
    return r;
  endfunction

  task automatic model_seed(input longint unsigned sd, input longint unsigned st);
    m_inc   = (st << 1) | 64'd1;
    m_state = 0;
    m_state = m_state * 64'd6364136223846793005 + m_inc;
    m_state = m_state + sd;
    m_state = m_state * 64'd6364136223846793005 + m_inc;
    m_half  = 1'b0;
  endtask

  function automatic logic [31:0] model_draw();
    logic [31:0] w;
    w = model_word(m_state);
    if ((m_state >> 59) == 0) rot0_seen++;
    m_state = m_state * 64'd6364136223846793005 + m_inc;
    return w;
  endfunction

  // driver side: strobe and push expectations
  task automatic push_draw();
    logic [31:0] w;
    w = model_draw();
    exp_q.push_back(w);
    if (!m_half) begin
      m_lo = w;
      m_half = 1'b1;
    end else begin
      wide_q.push_back({w, m_lo});
      m_half = 1'b0;
    end
  endtask

  task automatic draw_burst(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      next_i = 1'b1;
      push_draw();
      @(negedge clk);
      if (gap > 0) begin
        next_i = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    next_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(input logic [63:0] sd, input logic [63:0] st);
    seed_i = sd;
    stream_i = st;
    load_i = 1'b1;
    model_seed(sd, st);
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // monitor: R8 R10 R9 scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (word_valid_o) begin
        if (exp_q.size() == 0) check("R7 R8 unexpected word_valid", 64'd1, 64'd0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check("R2 R3 R4 R8 word", {32'd0, word_o}, {32'd0, e});
          check("R10 pos31", {32'd0, pos31_o}, {32'd0, e & 32'h7FFF_FFFF});
        end
      end
      if (wide_valid_o) begin
        if (wide_q.size() == 0) check("R9 unexpected wide_valid", 64'd1, 64'd0);
        else check("R9 wide", wide_o, wide_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12
    check("R12 ready after reset", {63'd0, ready_o}, 64'd0);
    check("R12 valid after reset", {62'd0, word_valid_o, wide_valid_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: strobe before any load is ignored
    next_i = 1'b1;
    @(negedge clk);
    next_i = 1'b0;
    @(negedge clk);
    check("R12 R7 no word before load", {63'd0, word_valid_o}, 64'd0);

    // R6 ready timing, R5 known sequence
    load(64'd42, 64'd54);
    for (int k = 1; k <= 3; k++) begin
      check("R6 ready low during seeding", {63'd0, ready_o}, 64'd0);
      @(negedge clk);
    end
    check("R6 ready on fourth edge", {63'd0, ready_o}, 64'd1);
    draw_burst(1, 0);
    check("R5 first word seed 42 stream 54", {32'd0, word_o}, 64'h0000_0000_A15C_02B7);
    draw_burst(12, 0);
    draw_burst(9, 2);

    // R7 R11: load while ready with strobes held through the seeding
    seed_i = 64'hDEAD_BEEF_0123_4567;
    stream_i = 64'h0000_0000_0000_0BAD;
    model_seed(seed_i, stream_i);
    load_i = 1'b1;
    next_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    check("R11 ready drops on load", {63'd0, ready_o}, 64'd0);
    for (int k = 0; k < 2; k++) begin
      check("R7 no word while seeding", {63'd0, word_valid_o}, 64'd0);
      @(negedge clk);
    end
    next_i = 1'b0;
    check("R7 no word while seeding", {63'd0, word_valid_o}, 64'd0);
    @(negedge clk);
    check("R6 R11 ready again", {63'd0, ready_o}, 64'd1);
    check("R7 no word on ready", {63'd0, word_valid_o}, 64'd0);
    draw_burst(31, 0);

    // R1: stream bit 63 ignored
    load(64'd7, 64'h0000_0000_1234_5678);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      draw_burst(1, 0);
      capt_a[i] = word_o;
    end
    load(64'd7, 64'h8000_0000_1234_5678);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      draw_burst(1, 0);
      check("R1 stream bit 63 no effect", {32'd0, word_o}, {32'd0, capt_a[i]});
    end

    // R9 R11: odd number of draws then reload restarts pairing
    load(64'h0F0F_0F0F_F0F0_F0F0, 64'd3);
    repeat (3) @(negedge clk);
    draw_burst(3, 1);
    load(64'd1, 64'd0);
    repeat (3) @(negedge clk);
    draw_burst(40, 0);

    // R4: extra draws to cover many rotation amounts
    draw_burst(60, 0);
    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", 64'(exp_q.size()), 64'd0);
    check("R9 wide scoreboard drained", 64'(wide_q.size()), 64'd0);
    $display("rotation-zero draws seen: %0d", rot0_seen);
    finish_run();
  end
endmodule